// File: doc/BRIEF.md
# Strap and Revision Control Register Bank

This block is a small bank of system-control registers on a plain 32-bit register bus. It holds four things: a key register that opens scratch writes, a hardware strap register, a fixed revision word and a few scratch words. The strap register is loaded from the strap pin inputs while reset is held.

The revision word is a parameter. The family field in its top byte selects how software changes the strap register at run time. In the newer family, writing the strap offset sets bits, and writing the revision offset clears strap bits. The revision word itself never changes. In the older family, writing the strap offset overwrites the whole register. A write to the revision offset is dropped, and the block raises a one-cycle illegal-write pulse. Reads are combinational, so data returns in the same cycle as the read strobe.

Top module: `strapbank`

## Requirements
- R1: While `rst_n` is low at a clock edge, the strap register takes `strap_pins`, the key register clears to 0, and every scratch word clears to 0.
- R2: A write to offset 0x00 sets the key register to 1 if the data is 0x1688A8A8, and to 0 for any other data. A read of offset 0x00 returns the key in bit 0, with zeros above it.
- R3: When `REV_ID[31:24]` is 0x04, a write to offset 0x70 ORs the write data into the strap register.
- R4: When `REV_ID[31:24]` is 0x04, a write to offset 0x7C clears each strap bit whose write data bit is 1. The other strap bits are left as they were.
- R5: When `REV_ID[31:24]` is not 0x04, a write to offset 0x70 replaces the strap register with the write data.
- R6: When `REV_ID[31:24]` is not 0x04, a write to offset 0x7C leaves the strap register unchanged. `bad_wr` is then high for the single cycle after the write edge. `bad_wr` never rises in the 0x04 family.
- R7: A write to scratch word i (offset 0x10 + 4*i) takes effect only while the key register is 1. Otherwise the word keeps its value.
- R8: While `bus_ren` is high, `bus_rdata` shows the addressed register in the same cycle. The strap register is at 0x70 and reads its current value. An unimplemented offset reads 0. While `bus_ren` is low, `bus_rdata` is 0.
- R9: A read of offset 0x7C always returns `REV_ID`, including right after writes to that offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_pins | input | 32 | Strap value loaded during reset |
| bus_addr | input | AW | Byte offset of the access |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |
| bad_wr | output | 1 | Pulse after a dropped revision write |

## Verification
The bench uses two instances on one shared bus, one of each family. Both receive the same walking set and clear sequences, and the strap value is read back after every write. A design that decodes the family wrongly would overwrite strap bits where they should accumulate, or change strap bits where a revision write should be dropped. A design that stores the clear data into the revision word would show a changed revision on read-back. The bench also tests near-miss key values and scratch writes with the key both locked and open. It checks that `bad_wr` lasts exactly one cycle, which catches a flag that sticks high or fires in the wrong family.

// File: rtl/strapbank.sv
module strapbank #(
  parameter logic [31:0] REV_ID = 32'h0400_0303,
  parameter int NSCR = 4,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   strap_pins,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wen,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_ren,
  output logic [31:0]   bus_rdata,
  output logic          bad_wr
);
  localparam logic [AW-1:0] A_KEY   = AW'('h00);
  localparam logic [AW-1:0] A_SCR0  = AW'('h10);
  localparam logic [AW-1:0] A_STRAP = AW'('h70);
  localparam logic [AW-1:0] A_REV   = AW'('h7C);
  localparam logic [31:0]   MAGIC   = 32'h1688_A8A8;
  localparam bit NEWF = (REV_ID[31:24] == 8'h04);

  logic [31:0] strap_q;
  logic        key_q;
  logic [31:0] scr_q [NSCR];
  logic [31:0] rd;

  wire wr_key   = bus_wen && bus_addr == A_KEY;
  wire wr_strap = bus_wen && bus_addr == A_STRAP;
  wire wr_rev   = bus_wen && bus_addr == A_REV;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_q <= strap_pins;
      key_q   <= 1'b0;
      bad_wr  <= 1'b0;
    end else begin
      if (wr_strap)
        strap_q <= NEWF ? (strap_q | bus_wdata) : bus_wdata;
      else if (wr_rev && NEWF)
        strap_q <= strap_q & ~bus_wdata;
      if (wr_key)
        key_q <= (bus_wdata == MAGIC);
      bad_wr <= wr_rev && !NEWF;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSCR; i++) begin
      if (!rst_n)
        scr_q[i] <= '0;
      else if (bus_wen && key_q && bus_addr == A_SCR0 + AW'(4 * i))
        scr_q[i] <= bus_wdata;
    end
  end

  always_comb begin
    rd = '0;
    case (bus_addr)
      A_KEY:   rd = {31'b0, key_q};
      A_STRAP: rd = strap_q;
      A_REV:   rd = REV_ID;
      default: rd = '0;
    endcase
    for (int i = 0; i < NSCR; i++)
      if (bus_addr == A_SCR0 + AW'(4 * i)) rd = scr_q[i];
  end

  assign bus_rdata = bus_ren ? rd : '0;
endmodule

module strapbank_chk #(
  parameter logic [31:0] REV_ID = 32'h0400_0303,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wen,
  input logic [31:0]   bus_wdata,
  input logic          bus_ren,
  input logic [31:0]   bus_rdata,
  input logic          bad_wr,
  input logic [31:0]   strap_q,
  input logic          key_q
);
  localparam bit NEWF = (REV_ID[31:24] == 8'h04);
  localparam logic [AW-1:0] A_KEY   = AW'('h00);
  localparam logic [AW-1:0] A_STRAP = AW'('h70);
  localparam logic [AW-1:0] A_REV   = AW'('h7C);

  assert_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == A_KEY) |=> key_q == ($past(bus_wdata) == 32'h1688_A8A8));

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (NEWF && bus_wen && bus_addr == A_STRAP) |=> strap_q == ($past(strap_q) | $past(bus_wdata)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (NEWF && bus_wen && bus_addr == A_REV) |=> strap_q == ($past(strap_q) & ~$past(bus_wdata)));

  assert_replace_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!NEWF && bus_wen && bus_addr == A_STRAP) |=> strap_q == $past(bus_wdata));

  assert_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!NEWF && bus_wen && bus_addr == A_REV) |=> (bad_wr && $stable(strap_q)));

  assert_noflag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!NEWF && bus_wen && bus_addr == A_REV) |=> !bad_wr);

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ren |-> bus_rdata == '0);

  assert_rev_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ren && bus_addr == A_REV) |-> bus_rdata == REV_ID);
endmodule

bind strapbank strapbank_chk #(.REV_ID(REV_ID), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
  .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
  .bad_wr(bad_wr), .strap_q(strap_q), .key_q(key_q));

// File: tb/sim_strapbank.sv
module sim_strapbank;
  localparam logic [31:0] REV_NEW = 32'h0401_0303;
  localparam logic [31:0] REV_OLD = 32'h0300_0303;
  localparam logic [31:0] PINS    = 32'hA5C3_0F18;
  localparam logic [31:0] MAGIC   = 32'h1688_A8A8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic wen = 1'b0, ren = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd0, rd1;
  logic bad0, bad1;
  int runs = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  strapbank #(.REV_ID(REV_NEW), .NSCR(4), .AW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_pins(PINS), .bus_addr(addr), .bus_wen(wen),
    .bus_wdata(wdata), .bus_ren(ren), .bus_rdata(rd0), .bad_wr(bad0));
  strapbank #(.REV_ID(REV_OLD), .NSCR(4), .AW(8)) u1 (
    .clk(clk), .rst_n(rst_n), .strap_pins(PINS), .bus_addr(addr), .bus_wen(wen),
    .bus_wdata(wdata), .bus_ren(ren), .bus_rdata(rd1), .bad_wr(bad1));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wen = 1'b1;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v0, output logic [31:0] v1);
    addr = a; ren = 1'b1; #1;
    v0 = rd0; v1 = rd1;
    ren = 1'b0; #1;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v0, v1, m0, m1, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h70, v0, v1); chk("R1 strap new", v0, PINS); chk("R1 strap old", v1, PINS);
    rd(8'h00, v0, v1); chk("R1 key", v0, 0); chk("R1 key old", v1, 0);
    for (int i = 0; i < 4; i++) begin
      rd(8'h10 + 8'(4 * i), v0, v1); chk("R1 scratch", v0, 0); chk("R1 scratch old", v1, 0);
    end
    #1; chk("R8 idle rdata", rd0, 0); chk("R8 idle rdata old", rd1, 0);
    rd(8'h44, v0, v1); chk("R8 unimpl", v0, 0); chk("R8 unimpl old", v1, 0);
    rd(8'h7C, v0, v1); chk("R9 rev new", v0, REV_NEW); chk("R9 rev old", v1, REV_OLD);

    m0 = PINS; m1 = PINS;
    wr(8'h70, 32'h0); m0 = m0 | 32'h0; m1 = 32'h0;
    rd(8'h70, v0, v1); chk("R3 set zero", v0, m0); chk("R5 replace zero", v1, m1);
    for (int i = 0; i < 32; i++) begin
      d = (32'h1 << i) | (32'h0101_0000 >> (i % 8));
      wr(8'h70, d); m0 = m0 | d; m1 = d;
      chk("R6 no flag on strap write", {31'b0, bad1}, 0);
      rd(8'h70, v0, v1); chk("R3 set", v0, m0); chk("R5 replace", v1, m1);
    end
    wr(8'h70, 32'hFFFF_FFFF); m0 = 32'hFFFF_FFFF; m1 = 32'hFFFF_FFFF;
    for (int i = 0; i < 32; i++) begin
      d = 32'h3 << i;
      wr(8'h7C, d); m0 = m0 & ~d;
      chk("R6 flag old", {31'b0, bad1}, 1); chk("R6 no flag new", {31'b0, bad0}, 0);
      rd(8'h70, v0, v1); chk("R4 clear", v0, m0); chk("R6 strap kept", v1, m1);
      rd(8'h7C, v0, v1); chk("R9 rev after write", v0, REV_NEW); chk("R9 rev old after", v1, REV_OLD);
    end
    @(negedge clk); chk("R6 flag one cycle", {31'b0, bad1}, 0);
    wr(8'h70, 32'h0000_00F0); m0 = m0 | 32'hF0; m1 = 32'hF0;
    wr(8'h7C, 32'h0000_0030); m0 = m0 & ~32'h30;
    rd(8'h70, v0, v1); chk("R4 clear after set", v0, m0); chk("R6 keep after set", v1, m1);

    wr(8'h10, 32'hDEAD_0001);
    rd(8'h10, v0, v1); chk("R7 locked", v0, 0); chk("R7 locked old", v1, 0);
    wr(8'h00, MAGIC ^ 32'h1);
    rd(8'h00, v0, v1); chk("R2 near miss", v0, 0);
    wr(8'h00, MAGIC);
    rd(8'h00, v0, v1); chk("R2 magic", v0, 1); chk("R2 magic old", v1, 1);
    for (int i = 0; i < 4; i++) begin
      wr(8'h10 + 8'(4 * i), 32'h5A00_0000 + 32'(i));
      rd(8'h10 + 8'(4 * i), v0, v1);
      chk("R7 open", v0, 32'h5A00_0000 + 32'(i)); chk("R7 open old", v1, 32'h5A00_0000 + 32'(i));
    end
    wr(8'h00, 32'h0);
    rd(8'h00, v0, v1); chk("R2 relock", v0, 0);
    wr(8'h14, 32'h1234_5678);
    rd(8'h14, v0, v1); chk("R7 relocked keeps", v0, 32'h5A00_0001);
    rd(8'h70, v0, v1); chk("R8 strap stable", v0, m0); chk("R8 strap stable old", v1, m1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule